// File: doc/BRIEF.md
# Multicycle PC-Relative Load Engine

This block fetches 32-bit instructions and executes one instruction kind: a PC-relative load word, `dest <= MEM[PC_next + sext(offset)]`. A Moore control unit steps a small datapath through the work. All internal transfers share one write bus. The bus links the PC, the sign-extended offset, a register file with a single write port, the ALU operand and result registers, the memory address register and the memory data register. The effective address is not produced by a dedicated adder. The PC and the offset are parked in two scratch entries of the register file, read back into the ALU operands, added, and returned over the bus to the address register. This takes five serialized cycles.

The block talks to an instruction memory and to a data memory through request/ready handshakes. A request is raised together with a valid address and is held until the memory answers with a one-cycle ready pulse, which carries the read data. Each completed load is reported on a write-back strobe that gives the destination register and the value written. Any opcode other than the load is fetched, decoded and dropped.

The control states and their transitions are as follows:
- ST_FETCH waits for instruction ready, then goes to ST_DECODE.
- ST_DECODE bumps the PC. It goes to ST_ADR_PC on a load and back to ST_FETCH otherwise.
- ST_ADR_PC, ST_ADR_OFS, ST_ADR_RD, ST_ADR_ADD and ST_ADR_MAR each take one cycle and follow one another in that order. ST_ADR_MAR goes to ST_DREAD.
- ST_DREAD waits for data ready, then goes to ST_WBACK.
- ST_WBACK goes to ST_FETCH.

Top module: `lwc_core`

## Requirements
- R1: After synchronous reset the PC is 0 and the controller is in ST_FETCH. `imem_req` is 1 with `imem_addr` = 0, and both `dmem_req` and `wb_valid` are 0.
- R2: In ST_FETCH, `imem_req` stays high and `imem_addr` (the PC) stays stable until a cycle with `imem_ready` = 1. The instruction word is taken in that cycle only. `imem_req` and `dmem_req` are never high together.
- R3: ST_DECODE adds 4 to the PC. Successive fetch addresses therefore step by 4 whatever the opcode.
- R4: A load is encoded with bits [31:26] = 6'h23, the destination register in bits [25:21], bits [20:16] ignored and the offset in bits [15:0]. The data address is the load's own address + 4 + the offset sign-extended to 32 bits, with 32-bit wraparound.
- R5: Address computation takes exactly five cycles. `dmem_req` first rises 6 clock edges after the edge that accepts the instruction (one decode cycle plus five address cycles).
- R6: In ST_DREAD, `dmem_req` stays high and `dmem_addr` stays stable until `dmem_ready` = 1. The read data is captured only in that cycle.
- R7: In the cycle after the data is accepted, `wb_valid` pulses for exactly one cycle, with `wb_reg` set to the destination field and `wb_data` set to the captured word. The next cycle fetches again.
- R8: An instruction whose bits [31:26] differ from 6'h23 goes from ST_DECODE back to ST_FETCH. It raises no `dmem_req` and no `wb_valid`.
- R9: At most one source drives the internal write bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | 32 | Instruction address (PC) |
| imem_ready | input | 1 | One-cycle pulse: instruction word valid |
| imem_rdata | input | 32 | Instruction word |
| dmem_req | output | 1 | Data read request |
| dmem_addr | output | 32 | Data address (address register) |
| dmem_ready | input | 1 | One-cycle pulse: data word valid |
| dmem_rdata | input | 32 | Data word |
| wb_valid | output | 1 | Register write-back strobe |
| wb_reg | output | 5 | Destination register of the write-back |
| wb_data | output | 32 | Value written back |

## Verification
A corrupted state sequence shows up at the ports within one instruction, and the symptoms depend on where the fault lies:
- A skipped or repeated address state moves the first `dmem_req` away from its fixed distance of 6 edges after the instruction is accepted.
- A wrong bus source or a wrong scratch entry corrupts `dmem_addr` as soon as the data request appears.
- A wrong data capture or a wrong destination decode appears on `wb_data` or `wb_reg` in the single write-back cycle.
- A missed PC bump, or a non-load opcode that takes the load path, shows up as a wrong next fetch address or as an extra data request.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADR_PC,
        ST_ADR_OFS,
        ST_ADR_RD,
        ST_ADR_ADD,
        ST_ADR_MAR,
        ST_DREAD,
        ST_WBACK
    } lwc_state_e;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_SCR0,
        WR_SCR1,
        WR_DEST
    } lwc_wsel_e;

    localparam int BUS_SRC_N = 4;
    localparam int SRC_PC    = 0;
    localparam int SRC_OFS   = 1;
    localparam int SRC_ALU   = 2;
    localparam int SRC_MDR   = 3;

    typedef struct packed {
        logic                 fetch_req;
        logic                 pc_bump;
        logic [BUS_SRC_N-1:0] bus_src;
        lwc_wsel_e            wsel;
        logic                 alu_in_ld;
        logic                 alu_out_ld;
        logic                 mar_ld;
        logic                 data_req;
        logic                 wb_strobe;
    } lwc_ctl_t;

endpackage

// File: rtl/lwc_ctrl.sv
module lwc_ctrl
    import lwc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     imem_ready,
    input  logic     dmem_ready,
    input  logic     is_load,
    output lwc_ctl_t ctl
);

    lwc_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:   if (imem_ready) state_nx = ST_DECODE;
            ST_DECODE:  state_nx = is_load ? ST_ADR_PC : ST_FETCH;
            ST_ADR_PC:  state_nx = ST_ADR_OFS;
            ST_ADR_OFS: state_nx = ST_ADR_RD;
            ST_ADR_RD:  state_nx = ST_ADR_ADD;
            ST_ADR_ADD: state_nx = ST_ADR_MAR;
            ST_ADR_MAR: state_nx = ST_DREAD;
            ST_DREAD:   if (dmem_ready) state_nx = ST_WBACK;
            ST_WBACK:   state_nx = ST_FETCH;
            default:    state_nx = ST_FETCH;
        endcase
    end

    // Moore outputs: a function of the current state only
    always_comb begin
        ctl      = '0;
        ctl.wsel = WR_NONE;
        unique case (state)
            ST_FETCH:   ctl.fetch_req = 1'b1;
            ST_DECODE:  ctl.pc_bump = 1'b1;
            ST_ADR_PC: begin
                ctl.bus_src[SRC_PC] = 1'b1;
                ctl.wsel            = WR_SCR0;
            end
            ST_ADR_OFS: begin
                ctl.bus_src[SRC_OFS] = 1'b1;
                ctl.wsel             = WR_SCR1;
            end
            ST_ADR_RD:  ctl.alu_in_ld = 1'b1;
            ST_ADR_ADD: ctl.alu_out_ld = 1'b1;
            ST_ADR_MAR: begin
                ctl.bus_src[SRC_ALU] = 1'b1;
                ctl.mar_ld           = 1'b1;
            end
            ST_DREAD:   ctl.data_req = 1'b1;
            ST_WBACK: begin
                ctl.bus_src[SRC_MDR] = 1'b1;
                ctl.wsel             = WR_DEST;
                ctl.wb_strobe        = 1'b1;
            end
            default: ;
        endcase
    end

    assert_bus_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctl.bus_src));

    assert_adr_chain_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DREAD && $past(state) != ST_DREAD) |-> $past(state, 5) == ST_ADR_PC);

endmodule

// File: rtl/lwc_regfile.sv
module lwc_regfile #(
    parameter int DW    = 32,
    parameter int NARCH = 32,
    parameter int NSCR  = 2,
    localparam int NENT = NARCH + NSCR,
    localparam int AW   = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem [NENT];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/lwc_datapath.sv
module lwc_datapath
    import lwc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          OFS_W    = 16,
    parameter int          RA_W     = 5,
    parameter int          OPC_W    = 6,
    parameter logic [5:0]  LOAD_OPC = 6'h23,
    parameter int          PC_STEP  = 4,
    localparam int NARCH  = 1 << RA_W,
    localparam int RF_AW  = $clog2(NARCH + 2),
    localparam int DEST_LO = XLEN - OPC_W - RA_W,
    localparam int SPARE_W = DEST_LO - OFS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  lwc_ctl_t        ctl,
    input  logic            imem_ready,
    input  logic [XLEN-1:0] imem_rdata,
    input  logic            dmem_ready,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] mar,
    output logic            is_load,
    output logic [RA_W-1:0] wb_reg,
    output logic [XLEN-1:0] wb_data
);

    logic [XLEN-1:0] ir, mdr, alu_a, alu_b, alu_o, ofs_ext, wbus;
    logic [XLEN-1:0] rd_a, rd_b;
    logic [RA_W-1:0] dest;
    logic            rf_we;
    logic [RF_AW-1:0] rf_waddr;
    logic            spare_unused;

    assign dest         = ir[DEST_LO +: RA_W];
    assign ofs_ext      = {{(XLEN-OFS_W){ir[OFS_W-1]}}, ir[OFS_W-1:0]};
    assign is_load      = (ir[XLEN-1 -: OPC_W] == OPC_W'(LOAD_OPC));
    assign spare_unused = ^ir[OFS_W +: SPARE_W];

    always_ff @(posedge clk) begin
        if (rst)              pc <= '0;
        else if (ctl.pc_bump) pc <= pc + XLEN'(PC_STEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir  <= '0;
            mdr <= '0;
            mar <= '0;
        end else begin
            if (ctl.fetch_req && imem_ready) ir  <= imem_rdata;
            if (ctl.data_req && dmem_ready)  mdr <= dmem_rdata;
            if (ctl.mar_ld)                  mar <= wbus;
        end
    end

    // write bus: AND-OR of the gated sources
    logic [XLEN-1:0] bus_in   [BUS_SRC_N];
    logic [XLEN-1:0] bus_part [BUS_SRC_N+1];
    assign bus_in[SRC_PC]  = pc;
    assign bus_in[SRC_OFS] = ofs_ext;
    assign bus_in[SRC_ALU] = alu_o;
    assign bus_in[SRC_MDR] = mdr;
    assign bus_part[0]     = '0;
    for (genvar g = 0; g < BUS_SRC_N; g++) begin : g_bus
        assign bus_part[g+1] = bus_part[g] | (bus_in[g] & {XLEN{ctl.bus_src[g]}});
    end
    assign wbus = bus_part[BUS_SRC_N];

    always_comb begin
        rf_we    = 1'b1;
        rf_waddr = RF_AW'(dest);
        unique case (ctl.wsel)
            WR_NONE: rf_we    = 1'b0;
            WR_SCR0: rf_waddr = RF_AW'(NARCH);
            WR_SCR1: rf_waddr = RF_AW'(NARCH + 1);
            WR_DEST: rf_waddr = RF_AW'(dest);
            default: rf_we    = 1'b0;
        endcase
    end

    lwc_regfile #(.DW(XLEN), .NARCH(NARCH), .NSCR(2)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (wbus),
        .raddr_a (RF_AW'(NARCH)),
        .raddr_b (RF_AW'(NARCH + 1)),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_a <= '0;
            alu_b <= '0;
            alu_o <= '0;
        end else begin
            if (ctl.alu_in_ld) begin
                alu_a <= rd_a;
                alu_b <= rd_b;
            end
            if (ctl.alu_out_ld) alu_o <= alu_a + alu_b;
        end
    end

    assign wb_reg  = dest;
    assign wb_data = wbus;

endmodule

// File: rtl/lwc_core.sv
module lwc_core
    import lwc_pkg::*;
#(
    parameter int         XLEN     = 32,
    parameter int         OFS_W    = 16,
    parameter int         RA_W     = 5,
    parameter int         OPC_W    = 6,
    parameter logic [5:0] LOAD_OPC = 6'h23,
    parameter int         PC_STEP  = 4
) (
    input  logic            clk,
    input  logic            rst,
    output logic            imem_req,
    output logic [XLEN-1:0] imem_addr,
    input  logic            imem_ready,
    input  logic [XLEN-1:0] imem_rdata,
    output logic            dmem_req,
    output logic [XLEN-1:0] dmem_addr,
    input  logic            dmem_ready,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            wb_valid,
    output logic [RA_W-1:0] wb_reg,
    output logic [XLEN-1:0] wb_data
);

    lwc_ctl_t ctl;
    logic     is_load;

    lwc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .imem_ready (imem_ready),
        .dmem_ready (dmem_ready),
        .is_load    (is_load),
        .ctl        (ctl)
    );

    lwc_datapath #(
        .XLEN(XLEN), .OFS_W(OFS_W), .RA_W(RA_W), .OPC_W(OPC_W),
        .LOAD_OPC(LOAD_OPC), .PC_STEP(PC_STEP)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .imem_ready (imem_ready),
        .imem_rdata (imem_rdata),
        .dmem_ready (dmem_ready),
        .dmem_rdata (dmem_rdata),
        .pc         (imem_addr),
        .mar        (dmem_addr),
        .is_load    (is_load),
        .wb_reg     (wb_reg),
        .wb_data    (wb_data)
    );

    assign imem_req = ctl.fetch_req;
    assign dmem_req = ctl.data_req;
    assign wb_valid = ctl.wb_strobe;

    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_req && imem_addr == '0 && !dmem_req && !wb_valid));

    assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (imem_req && !imem_ready) |=> (imem_req && $stable(imem_addr)));

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(imem_req && dmem_req));

    assert_dread_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (dmem_req && !dmem_ready) |=> (dmem_req && $stable(dmem_addr)));

    assert_wb_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> (!wb_valid && imem_req));

endmodule

// File: tb/lwc_core_bench.sv
module lwc_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_req, dmem_req, wb_valid;
    logic [31:0] imem_addr, dmem_addr, wb_data;
    logic        imem_ready = 1'b0, dmem_ready = 1'b0;
    logic [31:0] imem_rdata = 32'hFFFF_FFFF, dmem_rdata = 32'hDEAD_BEEF;
    logic [4:0]  wb_reg;

    lwc_core u_lwc_core (
        .clk(clk), .rst(rst),
        .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_ready(imem_ready), .imem_rdata(imem_rdata),
        .dmem_req(dmem_req), .dmem_addr(dmem_addr),
        .dmem_ready(dmem_ready), .dmem_rdata(dmem_rdata),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int acc_cyc = 0, dreq_n = 0, wb_n = 0;
    logic [31:0] exp_pc = '0;
    bit done = 1'b0;
    localparam logic [31:0] END_PC = 32'd28;

    logic [31:0] imem [16];
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    logic [4:0]  q_rd   [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dval(input logic [31:0] a);
        return a ^ 32'hC3A5_0F1E ^ {a[15:0], a[31:16]};
    endfunction

    // driver: places a load and queues its expected outcome (R4 encoding)
    task automatic push_load(input int idx, input logic [4:0] rd, input logic [15:0] off);
        logic [31:0] ea;
        imem[idx] = {6'h23, rd, 5'b10101, off};
        ea = 32'(idx * 4) + 32'd4 + {{16{off[15]}}, off};
        q_addr.push_back(ea);
        q_rd.push_back(rd);
        q_data.push_back(dval(ea));
    endtask

    task automatic push_other(input int idx, input logic [5:0] opc);
        imem[idx] = {opc, 26'h2AB_CDEF};
    endtask

    // instruction memory responder
    initial begin
        wait (!rst);
        forever begin
            @(negedge clk);
            if (imem_req && !done) begin
                chk(imem_addr == exp_pc, "R3", "fetch address", imem_addr, exp_pc);
                if (imem_addr == END_PC) begin
                    done = 1'b1;
                end else begin
                    logic [31:0] a0;
                    a0 = imem_addr;
                    for (int k = 0; k < int'(a0[5:2]) % 3; k++) begin
                        @(negedge clk);
                        chk(imem_req && imem_addr == a0, "R2", "fetch hold", imem_addr, a0);
                    end
                    imem_rdata = imem[a0[5:2]];
                    imem_ready = 1'b1;
                    acc_cyc    = cyc + 1;
                    exp_pc     = a0 + 32'd4;
                    @(negedge clk);
                    imem_ready = 1'b0;
                    imem_rdata = 32'hFFFF_FFFF;
                end
            end
        end
    end

    // data memory responder
    initial begin
        wait (!rst);
        forever begin
            @(negedge clk);
            if (dmem_req) begin
                logic [31:0] a0, ea;
                a0 = dmem_addr;
                dreq_n++;
                chk(imem_req == 1'b0, "R2", "both requests high", 32'(imem_req), 32'd0);
                chk(cyc == acc_cyc + 6, "R5", "data request cycle", 32'(cyc), 32'(acc_cyc + 6));
                ea = (q_addr.size() > 0) ? q_addr.pop_front() : 32'hX;
                chk(a0 == ea, "R4", "data address", a0, ea);
                for (int k = 0; k < int'(a0 >> 2) % 3; k++) begin
                    @(negedge clk);
                    chk(dmem_req && dmem_addr == a0, "R6", "data hold", dmem_addr, a0);
                end
                dmem_rdata = dval(a0);
                dmem_ready = 1'b1;
                @(negedge clk);
                dmem_ready = 1'b0;
                dmem_rdata = 32'hDEAD_BEEF;
            end
        end
    end

    // write-back monitor: scoreboard pop and compare (R7; R9 shows as intact wb_data)
    initial begin
        wait (!rst);
        forever begin
            @(negedge clk);
            if (wb_valid) begin
                wb_n++;
                if (q_rd.size() == 0) begin
                    chk(1'b0, "R8", "unexpected write-back", 32'(wb_reg), 32'd0);
                end else begin
                    logic [4:0]  er;
                    logic [31:0] ed;
                    er = q_rd.pop_front();
                    ed = q_data.pop_front();
                    chk(wb_reg == er, "R7", "write-back register", 32'(wb_reg), 32'(er));
                    chk(wb_data == ed, "R7", "write-back data", wb_data, ed);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 32'(cyc), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) imem[i] = '0;
        push_load(0, 5'd3, 16'h0008);
        push_load(1, 5'd7, 16'hFFFC);
        push_other(2, 6'h00);
        push_load(3, 5'd31, 16'h7FFF);
        push_load(4, 5'd0, 16'h8000);
        push_other(5, 6'h3F);
        push_load(6, 5'd15, 16'h0000);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(imem_req == 1'b1, "R1", "reset fetch request", 32'(imem_req), 32'd1);
        chk(imem_addr == 32'd0, "R1", "reset pc", imem_addr, 32'd0);
        chk(dmem_req == 1'b0, "R1", "reset data request", 32'(dmem_req), 32'd0);
        chk(wb_valid == 1'b0, "R1", "reset write-back", 32'(wb_valid), 32'd0);
        rst = 1'b0;

        wait (done);
        repeat (4) @(negedge clk);
        chk(dreq_n == 5, "R8", "data request count", 32'(dreq_n), 32'd5);
        chk(wb_n == 5, "R8", "write-back count", 32'(wb_n), 32'd5);
        chk(q_rd.size() == 0, "R7", "pending write-backs", 32'(q_rd.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule